// File: doc/BRIEF.md
# Serial Port Data/Status Word

This block gives a processor one 16-bit register that connects it to a byte-wide serial line. When the processor reads the register, the upper byte holds the last received character and the lower byte holds the status flags. When the processor writes the upper byte, the character goes to the transmitter. The transmit shifter and the receive sampler are both inside the block. Each runs from a fixed clock divider, `CLK_DIV` system clocks per bit.

Each character takes ten bit times on the line: a low start bit, eight data bits with the least significant bit first, and a high stop bit. The line idles high. The receiver checks the start bit at mid-bit and then samples every later bit at mid-bit. If the start bit is not still low at mid-bit, the receiver treats it as a glitch and drops it. A read that the bus accepts consumes the received byte, and the data-ready flag clears as a side effect. If a new byte arrives before the old one has been read, the new byte replaces it and a sticky overrun flag is raised.

The bus side has a chip select `sel`, a direction strobe `wr` (1 = write, 0 = read), a 16-bit write path and a 16-bit read path. The read path always shows the current register contents, but state changes only on a cycle with `sel` high.

Top module: `uart_word_port`

## Requirements
- R1: After reset, `txd` is 1 and `rdata` is 0x0000: no byte ready, transmitter idle, no overrun.
- R2: `rdata[15:8]` is the received byte, `rdata[0]` is data-ready, `rdata[1]` is transmitter-busy, `rdata[2]` is overrun, and `rdata[7:3]` always read as 0.
- R3: A write (`sel`=1, `wr`=1) while busy is 0 sends `wdata[15:8]` starting at the next clock edge: start bit 0, then data bits 0 to 7, then stop bit 1. Each bit lasts `CLK_DIV` clocks.
- R4: After an accepted write, busy reads 1 for exactly 10*`CLK_DIV` clocks and then returns to 0, and `txd` is then high.
- R5: A write while busy is 1 is ignored: the frame already on `txd` goes on unchanged.
- R6: A well-formed frame on `rxd` sets data-ready to 1 and puts its 8 data bits in `rdata[15:8]`.
- R7: A read (`sel`=1, `wr`=0) clears data-ready and overrun at that clock edge. Without `sel`, or during a write, both flags keep their values.
- R8: When a byte arrives while data-ready is still 1, the new byte replaces the old one and overrun becomes 1.
- R9: A low pulse on `rxd` that has ended by mid-bit does not deliver a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Register select |
| wr | input | 1 | 1 = write, 0 = read |
| wdata | input | 16 | Write data; bits 15:8 are the character to send |
| rdata | output | 16 | Received byte in bits 15:8, status flags in bits 7:0 |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line (asynchronous) |

## Verification
A receive bit counter off by one shifts every received byte by one position. The same fault can also make the receiver accept the stop bit as data, so a single frame already exposes it in `rdata[15:8]`. A transmit counter fault shows up as a `txd` bit sampled at the wrong mid-bit point, or as busy falling one clock early or late, within the first frame. A flag that clears or sets on the wrong bus cycle appears in `rdata[2:0]` at the next clock edge.

// File: rtl/uart_word_port.sv
module uart_word_port #(
  parameter int CLK_DIV = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel,
  input  logic        wr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        txd,
  input  logic        rxd
);
  localparam int CW   = $clog2(CLK_DIV + 1);
  localparam int HALF = CLK_DIV / 2;

  logic          tx_act;
  logic [9:0]    tx_sh;
  logic [3:0]    tx_bit;
  logic [CW-1:0] tx_cnt;

  logic [1:0]    rx_sync;
  logic          rx_s;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_st_t;
  rx_st_t        rx_st;
  logic [CW-1:0] rx_cnt;
  logic [2:0]    rx_bit;
  logic [7:0]    rx_sh;
  logic [7:0]    rx_byte;
  logic          rx_done;
  logic          ready, ovr;

  wire wr_go  = sel && wr && !tx_act;
  wire rd_go  = sel && !wr;
  wire tx_tick = (tx_cnt == CW'(CLK_DIV - 1));
  wire rx_tick = (rx_cnt == CW'(CLK_DIV - 1));

  assign rdata = {rx_byte, 5'b0, ovr, tx_act, ready};
  assign txd   = tx_act ? tx_sh[0] : 1'b1;
  assign rx_s  = rx_sync[1];
  assign rx_done = (rx_st == RX_STOP) && rx_tick && rx_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_act <= 1'b0;
      tx_sh  <= '1;
      tx_bit <= '0;
      tx_cnt <= '0;
    end else if (wr_go) begin
      tx_act <= 1'b1;
      tx_sh  <= {1'b1, wdata[15:8], 1'b0};
      tx_bit <= '0;
      tx_cnt <= '0;
    end else if (tx_act) begin
      if (tx_tick) begin
        tx_cnt <= '0;
        if (tx_bit == 4'd9) tx_act <= 1'b0;
        else begin
          tx_sh  <= {1'b1, tx_sh[9:1]};
          tx_bit <= tx_bit + 4'd1;
        end
      end else tx_cnt <= tx_cnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_sync <= 2'b11;
    else        rx_sync <= {rx_sync[0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_st  <= RX_IDLE;
      rx_cnt <= '0;
      rx_bit <= '0;
      rx_sh  <= '0;
    end else begin
      case (rx_st)
        RX_IDLE: begin
          rx_cnt <= '0;
          if (!rx_s) rx_st <= RX_START;
        end
        RX_START: begin
          if (rx_cnt == CW'(HALF - 1)) begin
            rx_cnt <= '0;
            rx_bit <= '0;
            rx_st  <= rx_s ? RX_IDLE : RX_DATA;
          end else rx_cnt <= rx_cnt + CW'(1);
        end
        RX_DATA: begin
          if (rx_tick) begin
            rx_cnt <= '0;
            rx_sh  <= {rx_s, rx_sh[7:1]};
            rx_bit <= rx_bit + 3'd1;
            if (rx_bit == 3'd7) rx_st <= RX_STOP;
          end else rx_cnt <= rx_cnt + CW'(1);
        end
        default: begin
          if (rx_tick) begin
            rx_cnt <= '0;
            rx_st  <= RX_IDLE;
          end else rx_cnt <= rx_cnt + CW'(1);
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_byte <= '0;
      ready   <= 1'b0;
      ovr     <= 1'b0;
    end else if (rx_done) begin
      rx_byte <= rx_sh;
      ready   <= 1'b1;
      if (ready && !rd_go) ovr <= 1'b1;
      else if (rd_go)      ovr <= 1'b0;
    end else if (rd_go) begin
      ready <= 1'b0;
      ovr   <= 1'b0;
    end
  end

  assert_tx_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && !rdata[1]) |=> (rdata[1] && !txd));
  assert_busy_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && rdata[1] && !tx_tick) |=> $stable(tx_sh) && $stable(tx_bit));
  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !wr && !rx_done) |=> (!rdata[0] && !rdata[2]));
  assert_overrun_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rdata[0] && !(sel && !wr)) |=> rdata[2]);
  assert_ready_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdata[0]) |-> $past(rx_st == RX_STOP));
  assert_idle_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdata[1]) |-> txd);
endmodule

// File: tb/tb_uart_word_port.sv
module tb_uart_word_port;
  localparam int DIV = 8;
  logic clk = 0, rst_n = 0, sel = 0, wr = 0, rxd = 1;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic txd;
  int vecs = 0, errs = 0;
  bit done = 0;

  uart_word_port #(.CLK_DIV(DIV)) dut (.clk, .rst_n, .sel, .wr, .wdata, .rdata, .txd, .rxd);

  always #10 clk = ~clk;

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_rx(logic [7:0] b);
    logic [9:0] fr;
    fr = {1'b1, b, 1'b0};
    for (int k = 0; k < 10; k++) begin
      @(negedge clk) rxd = fr[k];
      repeat (DIV - 1) @(negedge clk);
    end
    rxd = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic do_read(string req, logic [15:0] exp);
    @(negedge clk);
    sel = 1; wr = 0;
    chk(req, rdata, exp);
    @(negedge clk);
    sel = 0;
  endtask

  task automatic tx_frame(logic [7:0] b, bit poke);
    logic [9:0] fr;
    fr = {1'b1, b, 1'b0};
    @(negedge clk);
    sel = 1; wr = 1; wdata = {b, 8'h00};
    @(negedge clk);
    sel = 0;
    repeat (DIV / 2) @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      chk(poke ? "R5" : "R3", {15'd0, txd}, {15'd0, fr[k]});
      if (poke && k == 2) begin sel = 1; wr = 1; wdata = {~b, 8'h00}; end
      if (poke && k == 5) sel = 0;
      if (k < 9) repeat (DIV) @(negedge clk);
    end
    repeat (DIV / 2 - 1) @(negedge clk);
    chk("R4", {15'd0, rdata[1]}, 16'd1);
    @(negedge clk);
    chk("R4", {15'd0, rdata[1]}, 16'd0);
    chk("R4", {15'd0, txd}, 16'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", rdata, 16'h0000);
    chk("R1", {15'd0, txd}, 16'd1);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 256; v++) begin
      send_rx(v[7:0]);
      chk("R6", rdata, {v[7:0], 8'h01});
      do_read("R7", {v[7:0], 8'h01});
      chk("R7", rdata, {v[7:0], 8'h00});
    end

    for (int v = 0; v < 256; v++) tx_frame(v[7:0], 0);
    tx_frame(8'h3C, 1);
    tx_frame(8'hC3, 1);

    send_rx(8'h11);
    repeat (5) @(negedge clk);
    chk("R7", rdata, 16'h1101);
    @(negedge clk) begin sel = 1; wr = 1; wdata = 16'h0000; end
    @(negedge clk) sel = 0;
    repeat (DIV * 10 + 2) @(negedge clk);
    chk("R7", rdata & 16'hFFFD, 16'h1101);
    send_rx(8'h22);
    chk("R8", rdata, 16'h2205);
    chk("R2", {11'd0, rdata[7:3]}, 16'd0);
    do_read("R8", 16'h2205);
    chk("R8", rdata, 16'h2200);

    @(negedge clk) rxd = 0;
    repeat (2) @(negedge clk);
    rxd = 1;
    repeat (DIV * 12) @(negedge clk);
    chk("R9", rdata, 16'h2200);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errs++; vecs++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule